// File: doc/BRIEF.md
# Pulse-Qualified Saturating Trim Counter

This block turns excursions of a single three-level control wire into up and down steps of a 7-bit trim code that drives a current DAC. External comparators have already split the wire into three digital flags: one for below mid-level, one for above mid-level and one for the program level. A low excursion that lasts long enough raises the code by one. A high excursion of the same length lowers it by one. Every width is measured in ticks of a prescaler, so the accept window and the mid-level gap are parameters.

Several rules keep stray activity off the code. Short excursions are dropped. Each excursion gives at most one step. The wire must rest at mid-level for a minimum gap before a new excursion counts. The first excursion that qualifies after reset is discarded, because the comparator state is unknown at start-up. An enable input gates every step. The code saturates at both ends and never wraps. A high excursion that reaches the program level is never taken as a decrement. A memory controller can preload the code through a load port.

Top module: `trim_step_ctr`

## Requirements
- R1: After reset the trim code is RESET_CODE (default 0).
- R2: When loadValid is high at a clock edge, the trim code equals loadCode from the next cycle. This works whatever enable is, and it takes priority over any step.
- R3: After reset, the first excursion that meets the accept width changes nothing. Every later qualified excursion is counted.
- R4: A low excursion (lowFlag high) that lasts at least ACCEPT_TICKS ticks raises the trim code by exactly one.
- R5: A high excursion (highFlag high, progFlag low) that lasts at least ACCEPT_TICKS ticks lowers the trim code by exactly one.
- R6: An excursion shorter than ACCEPT_TICKS ticks leaves the trim code unchanged.
- R7: A single excursion yields at most one step, however long it lasts. A further step needs a return to mid-level first.
- R8: An excursion that starts before the wire has rested GAP_TICKS ticks at mid-level is not recognised and leaves the code unchanged.
- R9: A step up at code 127 leaves the code at 127.
- R10: A step down at code 0 leaves the code at 0.
- R11: An excursion that is accepted while enable is low leaves the trim code unchanged.
- R12: While progFlag is high, no decrement occurs. A high excursion with progFlag set at the start, or with progFlag rising during it, leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Step enable; when low, accepted excursions give no step |
| lowFlag | input | 1 | Wire is below mid-level |
| highFlag | input | 1 | Wire is above mid-level |
| progFlag | input | 1 | Wire is at the program level |
| loadValid | input | 1 | Preload strobe from the memory controller |
| loadCode | input | 7 | Value to preload |
| trimCode | output | 7 | Current trim code to the DAC |

## Verification
A step fires on the first tick at which the excursion has lasted ACCEPT_TICKS ticks. The step strobe is registered one cycle later and the code changes on the cycle after that, so the result is due no more than two cycles after acceptance. A load shows up one cycle after its strobe. Each stimulus task holds its excursion for a bounded number of cycles, then holds mid-level well past both the gap window and the two-cycle latency. Only then does it push the expected code to the scoreboard, which compares on a falling edge. Short and gap-violating pulses are sized so that, whatever the prescaler phase, they can never reach the tick counts they must stay under.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    S_GAP   = 2'd0,
    S_ARMED = 2'd1,
    S_EXC   = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic inc;
    logic dec;
  } stepStb_t;

endpackage

// File: rtl/trim_tick_gen.sv
module trim_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int DivW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DivW-1:0] DivLast = DivW'(TICK_DIV - 1);

  logic [DivW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt == DivLast) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == DivLast);

  // R4: width timing relies on isolated tick pulses
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int ACCEPT_TICKS = 8,
  parameter int GAP_TICKS    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     enable,
  input  logic     lowFlag,
  input  logic     highFlag,
  input  logic     progFlag,
  output stepStb_t stepStb
);
  localparam int AccW = (ACCEPT_TICKS > 1) ? $clog2(ACCEPT_TICKS) : 1;
  localparam int GapW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [AccW-1:0] AccLast = AccW'(ACCEPT_TICKS - 1);
  localparam logic [GapW-1:0] GapLast = GapW'(GAP_TICKS - 1);

  ctlState_t       state;
  logic [GapW-1:0] gapCnt;
  logic [AccW-1:0] widthCnt;
  logic            dirUp;
  logic            firstSeen;
  logic            midLevel;
  logic            stillOut;
  logic            accept;

  always_comb begin
    midLevel = !lowFlag && !highFlag;
    stillOut = dirUp ? lowFlag : (highFlag && !progFlag);
    accept   = (state == S_EXC) && stillOut && tick && (widthCnt == AccLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_GAP;
      gapCnt    <= '0;
      widthCnt  <= '0;
      dirUp     <= 1'b0;
      firstSeen <= 1'b0;
      stepStb   <= '0;
    end else begin
      stepStb <= '0;
      unique case (state)
        S_GAP: begin
          if (!midLevel) begin
            gapCnt <= '0;
          end else if (tick) begin
            if (gapCnt == GapLast) begin
              gapCnt <= '0;
              state  <= S_ARMED;
            end else begin
              gapCnt <= gapCnt + 1'b1;
            end
          end
        end
        S_ARMED: begin
          if (lowFlag) begin
            state    <= S_EXC;
            dirUp    <= 1'b1;
            widthCnt <= '0;
          end else if (highFlag) begin
            widthCnt <= '0;
            if (progFlag) begin
              state  <= S_GAP;
              gapCnt <= '0;
            end else begin
              state <= S_EXC;
              dirUp <= 1'b0;
            end
          end
        end
        S_EXC: begin
          if (!stillOut) begin
            state  <= S_GAP;
            gapCnt <= '0;
          end else if (tick) begin
            if (widthCnt == AccLast) begin
              state     <= S_GAP;
              gapCnt    <= '0;
              firstSeen <= 1'b1;
              if (firstSeen) begin
                stepStb.inc <= dirUp && enable;
                stepStb.dec <= !dirUp && enable;
              end
            end else begin
              widthCnt <= widthCnt + 1'b1;
            end
          end
        end
        default: state <= S_GAP;
      endcase
    end
  end

  // R7
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stepStb.inc, stepStb.dec}));
  // R11
  disabled_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !stepStb.inc && !stepStb.dec);
  // R12
  prog_no_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    progFlag |=> !stepStb.dec);
  // R3
  first_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !firstSeen |=> !stepStb.inc && !stepStb.dec);
endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg
  import trim_pkg::*;
#(
  parameter int               CODE_W     = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStb_t          stepStb,
  input  logic              loadValid,
  input  logic [CODE_W-1:0] loadCode,
  output logic [CODE_W-1:0] trimCode
);
  localparam logic [CODE_W-1:0] CodeMax = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  trimCode <= RESET_CODE;
    else if (loadValid)                         trimCode <= loadCode;
    else if (stepStb.inc && trimCode != CodeMax) trimCode <= trimCode + 1'b1;
    else if (stepStb.dec && trimCode != '0)      trimCode <= trimCode - 1'b1;
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> trimCode == $past(loadCode));
  // R9
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadValid && trimCode == CodeMax) |=> trimCode != '0);
  // R10
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadValid && trimCode == '0) |=> trimCode != CodeMax);
endmodule

// File: rtl/trim_step_ctr.sv
module trim_step_ctr
  import trim_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int TICK_DIV     = 4,
  parameter int ACCEPT_TICKS = 8,
  parameter int GAP_TICKS    = 3,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              lowFlag,
  input  logic              highFlag,
  input  logic              progFlag,
  input  logic              loadValid,
  input  logic [CODE_W-1:0] loadCode,
  output logic [CODE_W-1:0] trimCode
);
  logic     tick;
  stepStb_t stepStb;

  trim_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  trim_ctrl #(.ACCEPT_TICKS(ACCEPT_TICKS), .GAP_TICKS(GAP_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable),
    .lowFlag(lowFlag), .highFlag(highFlag), .progFlag(progFlag),
    .stepStb(stepStb)
  );

  trim_code_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) code_i (
    .clk(clk), .rstN(rstN), .stepStb(stepStb), .loadValid(loadValid),
    .loadCode(loadCode), .trimCode(trimCode)
  );
endmodule

// File: tb/trim_step_ctr_tb_top.sv
`timescale 1ns/1ps
module trim_step_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       lowFlag = 1'b0;
  logic       highFlag = 1'b0;
  logic       progFlag = 1'b0;
  logic       loadValid = 1'b0;
  logic [6:0] loadCode = '0;
  logic [6:0] trimCode;

  int applied = 0;
  int miscompares = 0;
  bit doneFlag = 0;

  typedef struct {
    logic [6:0] code;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  event chkEv;

  always #4 clk = ~clk;

  trim_step_ctr dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .lowFlag(lowFlag),
    .highFlag(highFlag), .progFlag(progFlag), .loadValid(loadValid),
    .loadCode(loadCode), .trimCode(trimCode)
  );

  // Scoreboard monitor
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        applied++;
        if (trimCode !== it.code) begin
          miscompares++;
          $display("FAIL %s: trimCode=%0d expected=%0d", it.tag, trimCode, it.code);
        end
      end
    end
  end

  task automatic expect_code(input logic [6:0] c, input string tag);
    expItem_t it;
    it.code = c;
    it.tag  = tag;
    expQ.push_back(it);
    ->chkEv;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // excursion: dir 0 = low, 1 = high; then rest at mid-level
  task automatic pulse(input bit dirHigh, input int width, input int rest);
    @(negedge clk);
    if (dirHigh) highFlag = 1'b1; else lowFlag = 1'b1;
    idle(width);
    lowFlag = 1'b0;
    highFlag = 1'b0;
    progFlag = 1'b0;
    idle(rest);
  endtask

  task automatic load(input logic [6:0] v);
    @(negedge clk);
    loadValid = 1'b1;
    loadCode  = v;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  localparam int LONG  = 40;
  localparam int SHORT = 20;
  localparam int REST  = 24;

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    expect_code(7'd0, "R1 reset value");
    idle(20);

    load(7'd60);
    expect_code(7'd60, "R2 preload");

    pulse(0, LONG, REST);
    expect_code(7'd60, "R3 first qualified pulse dropped");

    pulse(0, LONG, REST);
    expect_code(7'd61, "R4 low excursion increments");

    pulse(1, LONG, REST);
    expect_code(7'd60, "R5 high excursion decrements");

    pulse(0, SHORT, REST);
    expect_code(7'd60, "R6 short low rejected");
    pulse(1, SHORT, REST);
    expect_code(7'd60, "R6 short high rejected");

    pulse(0, 200, REST);
    expect_code(7'd61, "R7 long excursion gives one step");

    pulse(0, LONG, 4);
    pulse(0, LONG, REST);
    expect_code(7'd62, "R8 excursion inside gap ignored");

    enable = 1'b0;
    pulse(0, LONG, REST);
    expect_code(7'd62, "R11 low ignored while disabled");
    pulse(1, LONG, REST);
    expect_code(7'd62, "R11 high ignored while disabled");
    enable = 1'b1;

    @(negedge clk);
    progFlag = 1'b1;
    pulse(1, LONG, REST);
    expect_code(7'd62, "R12 program level not a decrement");

    @(negedge clk);
    highFlag = 1'b1;
    idle(16);
    progFlag = 1'b1;
    idle(30);
    highFlag = 1'b0;
    progFlag = 1'b0;
    idle(REST);
    expect_code(7'd62, "R12 program rise aborts decrement");

    load(7'd126);
    pulse(0, LONG, REST);
    expect_code(7'd127, "R4 step to max");
    pulse(0, LONG, REST);
    expect_code(7'd127, "R9 saturate at max");

    load(7'd1);
    pulse(1, LONG, REST);
    expect_code(7'd0, "R5 step to min");
    pulse(1, LONG, REST);
    expect_code(7'd0, "R10 saturate at min");

    @(negedge clk);
    enable = 1'b0;
    loadValid = 1'b1;
    loadCode = 7'd33;
    @(negedge clk);
    loadValid = 1'b0;
    enable = 1'b1;
    expect_code(7'd33, "R2 preload while disabled");

    doneFlag = 1;
  end

  initial begin
    int cycles = 0;
    while (!doneFlag && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!doneFlag) begin
      miscompares++;
      $display("FAIL watchdog: run hung, cycles=%0d expected<100000", cycles);
    end
    #2;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule